// File: doc/BRIEF.md
# Four-Moduli Residue-to-Binary Converter

This block turns a value held as four residues back into an ordinary unsigned binary integer. The residues are taken with respect to the pairwise coprime moduli 2^N, 2^(2N)+1, 2^N+1 and 2^N-1, where N is a compile-time parameter of at least 2. Their product M = 2^(5N) - 2^N sets the range of representable values, so the output is 5N bits wide and always lies in [0, M-1].

The residue modulo 2^N is passed straight through as the low N bits of the result. The upper 4N bits form a value Y that is a weighted sum of the residues, reduced modulo 2^(4N)-1. All of the weights are signed powers of two. Each weighted term is therefore a fixed rotation, bit inversion or concatenation of residue bits, and no multiplier or lookup table is needed. A wiring network builds five 4N-bit operands. Three carry-save levels with end-around carry reduce them to two vectors, and a modulo 2^(4N)-1 adder with end-around carry and an all-ones-to-zero fix-up produces Y. A parameter chooses between a purely combinational output and one registered stage.

The caller must supply valid residues, each one below its modulus. Forward conversion and residue checking are done elsewhere.

Top module: `rns_to_bin`

## Requirements
- R1: The low N bits of the output equal the residue modulo 2^N (input `res_m1`) unchanged.
- R2: For every valid residue tuple, the output is the unique integer X in [0, M-1] with X mod 2^N = `res_m1`, X mod (2^(2N)+1) = `res_m2`, X mod (2^N+1) = `res_m3` and X mod (2^N-1) = `res_m4`.
- R3: The upper 4N output bits (Y) are never all ones. The value zero of Y is encoded as all zeros, so the output never reaches M or above.
- R4: With `OUT_MODE` set to registered (the default), the output shows the conversion of the inputs sampled at the previous rising clock edge, and it holds its value between edges.
- R5: A synchronous active-high `rst` clears the registered output to zero at the next rising edge.
- R6: Each carry-save level wraps its top carry into bit 0. As a result, S + C after the three levels is congruent modulo 2^(4N)-1 to the sum of the five weighted operands.
- R7: The end points of the range convert correctly: the all-zero tuple gives 0, the tuple for M-1 gives Y = 2^(4N)-2 with low bits all ones, and any X below 2^N gives Y = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| res_m1 | input | N | Residue modulo 2^N |
| res_m2 | input | 2N+1 | Residue modulo 2^(2N)+1 |
| res_m3 | input | N+1 | Residue modulo 2^N+1 |
| res_m4 | input | N | Residue modulo 2^N-1 |
| x_out | output | 5N | Reconstructed binary integer X |

## Verification
The bench runs every X in the range for N = 3. Errors in a rotation amount, a missing inversion or a dropped wrap carry would corrupt results for particular residue digits, so this sweep exposes them. Random and directed vectors follow, covering zero, M-1 and values below 2^N. A design that forgot the all-ones-to-zero fix-up would output Y = all ones for some multiples of 2^N. A design that used an ordinary carry-save carry would lose the top carry, and its results would be off by a power-of-two multiple. The bench also checks that the output holds old data before the clock edge and that reset clears it. A design with the wrong latency, or with reset ignored, fails those checks.

// File: rtl/rns_conv_pkg.sv
package rns_conv_pkg;

    // Output timing variant of the converter.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REGD = 1'b1
    } out_mode_e;

    // Smallest supported modulus exponent (the x3/x4 weights use 2^(N-2)).
    localparam int unsigned MIN_N = 2;

    // Reduce a rotation amount into [0, w).
    function automatic int unsigned wrap_shift(input int unsigned k, input int unsigned w);
        return k % w;
    endfunction

endpackage

// File: rtl/rns_weight_net.sv
// Fixed wiring that forms the five 4N-bit weighted operands whose sum,
// modulo 2^(4N)-1, is the upper part Y of the result.
module rns_weight_net #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]            x1,
    input  logic [2*N:0]            x2,
    input  logic [N:0]              x3,
    input  logic [N-1:0]            x4,
    output logic [4:0][4*N-1:0]     ops
);
    import rns_conv_pkg::*;

    localparam int unsigned W4    = 4 * N;
    localparam int unsigned K_X2P = wrap_shift(3 * N - 1, W4);
    localparam int unsigned K_X2N = wrap_shift(N - 1, W4);
    localparam int unsigned K_X1N = wrap_shift(3 * N, W4);
    localparam int unsigned K_X3P = wrap_shift(N - 2, W4);
    localparam int unsigned K_X3N = wrap_shift(2 * N - 2, W4);
    localparam int unsigned K_X4P = wrap_shift(N - 2, W4);

    // Multiply by 2^k modulo 2^W4-1 for a value that is not all ones.
    function automatic logic [W4-1:0] rotl(input logic [W4-1:0] v, input int unsigned k);
        return (v << k) | (v >> (W4 - k));
    endfunction

    logic [W4-1:0] x1_ext;
    logic [W4-1:0] x2_ext;
    logic [W4-1:0] x3_pair;
    logic [W4-1:0] x4_quad;

    always_comb begin
        x1_ext  = {{(W4-N){1'b0}}, x1};
        x2_ext  = {{(W4-2*N-1){1'b0}}, x2};
        // x3 copies at bit 0 and bit 2N: the two same-sign terms are 2N apart.
        x3_pair = {{(N-1){1'b0}}, x3, {(N-1){1'b0}}, x3};
        // x4 weight has four positive terms spaced N apart.
        x4_quad = {x4, x4, x4, x4};

        // +2^(3N-1) * x2
        ops[0] = rotl(x2_ext, K_X2P);
        // -(2^(N-1) * x2) - (2^(3N) * x1): disjoint fields, one inversion
        ops[1] = ~(rotl(x2_ext, K_X2N) | rotl(x1_ext, K_X1N));
        // +(2^(N-2) + 2^(3N-2)) * x3
        ops[2] = rotl(x3_pair, K_X3P);
        // -(2^(2N-2) + 2^(4N-2)) * x3
        ops[3] = ~rotl(x3_pair, K_X3N);
        // +(2^(N-2) + 2^(2N-2) + 2^(3N-2) + 2^(4N-2)) * x4
        ops[4] = rotl(x4_quad, K_X4P);
    end

endmodule

// File: rtl/rns_csa_eac.sv
// One carry-save level whose top carry wraps into bit 0 (mod 2^W - 1).
module rns_csa_eac #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_v,
    output logic [W-1:0] car_v
);
    logic [W-1:0] maj;

    always_comb begin
        sum_v = in_a ^ in_b ^ in_c;
        maj   = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
        car_v = {maj[W-2:0], maj[W-1]};
    end

endmodule

// File: rtl/rns_modadd_eac.sv
// Modulo 2^W - 1 adder with end-around carry and a unique zero.
module rns_modadd_eac #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] op_s,
    input  logic [W-1:0] op_c,
    output logic [W-1:0] y
);
    logic [W:0]   raw;
    logic [W-1:0] wrapped;

    always_comb begin
        raw     = {1'b0, op_s} + {1'b0, op_c};
        wrapped = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
        y       = (&wrapped) ? '0 : wrapped;
    end

endmodule

// File: rtl/rns_to_bin.sv
module rns_to_bin #(
    parameter int unsigned                N        = 4,
    parameter rns_conv_pkg::out_mode_e    OUT_MODE = rns_conv_pkg::OUT_REGD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     res_m1,
    input  logic [2*N:0]     res_m2,
    input  logic [N:0]       res_m3,
    input  logic [N-1:0]     res_m4,
    output logic [5*N-1:0]   x_out
);
    import rns_conv_pkg::*;

    localparam int unsigned W4     = 4 * N;
    localparam int unsigned WX     = 5 * N;
    localparam int unsigned LEVELS = 3;

    typedef struct packed {
        logic [W4-1:0] sum_v;
        logic [W4-1:0] car_v;
    } csa_pair_t;

    logic [4:0][W4-1:0] ops;
    csa_pair_t          stage [LEVELS];
    logic [W4-1:0]      csa_s;
    logic [W4-1:0]      csa_c;
    logic [W4-1:0]      y_mod;
    logic [WX-1:0]      x_comb;

    rns_weight_net #(.N(N)) u_weights (
        .x1  (res_m1),
        .x2  (res_m2),
        .x3  (res_m3),
        .x4  (res_m4),
        .ops (ops)
    );

    // Three carry-save levels: 5 operands -> 2 vectors.
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_tree
        if (lv == 0) begin : g_first
            rns_csa_eac #(.W(W4)) u_csa (
                .in_a  (ops[0]),
                .in_b  (ops[1]),
                .in_c  (ops[2]),
                .sum_v (stage[lv].sum_v),
                .car_v (stage[lv].car_v)
            );
        end else begin : g_next
            rns_csa_eac #(.W(W4)) u_csa (
                .in_a  (stage[lv-1].sum_v),
                .in_b  (stage[lv-1].car_v),
                .in_c  (ops[lv+2]),
                .sum_v (stage[lv].sum_v),
                .car_v (stage[lv].car_v)
            );
        end
    end

    assign csa_s = stage[LEVELS-1].sum_v;
    assign csa_c = stage[LEVELS-1].car_v;

    rns_modadd_eac #(.W(W4)) u_final (
        .op_s (csa_s),
        .op_c (csa_c),
        .y    (y_mod)
    );

    assign x_comb = {y_mod, res_m1};

    if (OUT_MODE == OUT_REGD) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) x_out <= '0;
            else     x_out <= x_comb;
        end
    end else begin : g_comb
        assign x_out = x_comb;
    end

endmodule

// File: rtl/rns_to_bin_chk.sv
module rns_to_bin_chk #(
    parameter int unsigned             N        = 4,
    parameter rns_conv_pkg::out_mode_e OUT_MODE = rns_conv_pkg::OUT_REGD
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N-1:0]           res_m1,
    input logic [2*N:0]           res_m2,
    input logic [N:0]             res_m3,
    input logic [N-1:0]           res_m4,
    input logic [4:0][4*N-1:0]    ops,
    input logic [4*N-1:0]         csa_s,
    input logic [4*N-1:0]         csa_c,
    input logic [4*N-1:0]         y_mod,
    input logic [5*N-1:0]         x_comb,
    input logic [5*N-1:0]         x_out
);
    import rns_conv_pkg::*;

    localparam int unsigned W4 = 4 * N;
    localparam int unsigned WX = 5 * N;
    localparam int unsigned WS = W4 + 3;

    localparam logic [WX-1:0] MOD2 = (WX'(1) << (2 * N)) + WX'(1);
    localparam logic [WX-1:0] MOD3 = (WX'(1) << N) + WX'(1);
    localparam logic [WX-1:0] MOD4 = (WX'(1) << N) - WX'(1);
    localparam logic [WS-1:0] MODP = (WS'(1) << W4) - WS'(1);

    logic          in_valid;
    logic [WS-1:0] ops_total;
    logic [WS-1:0] sc_total;

    always_comb begin
        in_valid  = ({{(WX-2*N-1){1'b0}}, res_m2} < MOD2) &&
                    ({{(WX-N-1){1'b0}}, res_m3} < MOD3) &&
                    ({{(WX-N){1'b0}}, res_m4} < MOD4);
        ops_total = WS'(ops[0]) + WS'(ops[1]) + WS'(ops[2]) + WS'(ops[3]) + WS'(ops[4]);
        sc_total  = WS'(csa_s) + WS'(csa_c);
    end

    assert_csa_congruent_R6: assert property (@(posedge clk) disable iff (rst)
        (ops_total % MODP) == (sc_total % MODP));

    assert_y_canonical_R3: assert property (@(posedge clk) disable iff (rst)
        y_mod != '1);

    assert_out_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        x_out[WX-1:N] != '1);

    if (OUT_MODE == OUT_REGD) begin : g_reg_chk
        assert_low_passthru_R1: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> x_out[N-1:0] == $past(res_m1));

        assert_residues_R2: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> ((x_out % MOD2) == WX'($past(res_m2))) &&
                         ((x_out % MOD3) == WX'($past(res_m3))) &&
                         ((x_out % MOD4) == WX'($past(res_m4))));

        assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> x_out == $past(x_comb));

        assert_reset_clear_R5: assert property (@(posedge clk)
            rst |=> x_out == '0);
    end else begin : g_comb_chk
        assert_low_passthru_R1: assert property (@(posedge clk) disable iff (rst)
            x_out[N-1:0] == res_m1);

        assert_residues_R2: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> ((x_out % MOD2) == WX'(res_m2)) &&
                         ((x_out % MOD3) == WX'(res_m3)) &&
                         ((x_out % MOD4) == WX'(res_m4)));
    end

endmodule

bind rns_to_bin rns_to_bin_chk #(.N(N), .OUT_MODE(OUT_MODE)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .res_m1 (res_m1),
    .res_m2 (res_m2),
    .res_m3 (res_m3),
    .res_m4 (res_m4),
    .ops    (ops),
    .csa_s  (csa_s),
    .csa_c  (csa_c),
    .y_mod  (y_mod),
    .x_comb (x_comb),
    .x_out  (x_out)
);

// File: tb/rns_to_bin_bench.sv
module rns_to_bin_bench;

    localparam int unsigned N  = 3;
    localparam int unsigned WX = 5 * N;
    localparam longint P1 = longint'(1) << N;
    localparam longint P2 = (longint'(1) << (2 * N)) + 1;
    localparam longint P3 = (longint'(1) << N) + 1;
    localparam longint P4 = (longint'(1) << N) - 1;
    localparam longint MR = P1 * P2 * P3 * P4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    res_m1 = '0;
    logic [2*N:0]    res_m2 = '0;
    logic [N:0]      res_m3 = '0;
    logic [N-1:0]    res_m4 = '0;
    logic [WX-1:0]   x_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    rns_to_bin #(.N(N)) u_rns_to_bin (
        .clk    (clk),
        .rst    (rst),
        .res_m1 (res_m1),
        .res_m2 (res_m2),
        .res_m3 (res_m3),
        .res_m4 (res_m4),
        .x_out  (x_out)
    );

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive_value(input longint x);
        res_m1 = (N)'(x % P1);
        res_m2 = (2*N+1)'(x % P2);
        res_m3 = (N+1)'(x % P3);
        res_m4 = (N)'(x % P4);
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic convert_and_check(input string req, input longint x);
        @(negedge clk);
        drive_value(x);
        @(negedge clk);
        check(req, longint'(x_out), x);
    endtask

    initial begin
        int unsigned seed_dummy;
        longint prev;
        repeat (3) @(negedge clk);
        // R5: output held at zero by reset
        check("R5 reset state", longint'(x_out), 0);
        rst = 1'b0;

        // R7 corners
        convert_and_check("R7 zero tuple", 0);
        convert_and_check("R7 top of range", MR - 1);
        check("R7 top Y value", longint'(x_out[WX-1:N]), (longint'(1) << (4 * N)) - 2);
        convert_and_check("R7 below 2^N", P1 - 1);
        check("R7 Y zero below 2^N", longint'(x_out[WX-1:N]), 0);
        check("R1 low bits pass through", longint'(x_out[N-1:0]), P1 - 1);

        // R3 / R2: exhaustive sweep of the range
        for (longint x = 0; x < MR; x++) begin
            @(negedge clk);
            drive_value(x);
            @(negedge clk);
            if (x_out != (WX)'(x)) check("R2 exhaustive", longint'(x_out), x);
            else checks++;
            if (x_out[WX-1:N] == '1) check("R3 Y all ones", longint'(x_out[WX-1:N]), 0);
            if (x_out[N-1:0] != res_m1) check("R1 sweep low bits", longint'(x_out[N-1:0]), longint'(res_m1));
        end

        // R6: random vectors exercise the wrapped carry-save tree
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < 2000; i++) begin
            longint x;
            x = longint'($urandom) % MR;
            convert_and_check("R6 random", x);
        end

        // R4: output keeps previous value until the clock edge
        convert_and_check("R4 setup", 12345);
        prev = 12345;
        @(negedge clk);
        drive_value(777);
        #2;
        check("R4 hold before edge", longint'(x_out), prev);
        @(negedge clk);
        check("R4 update after edge", longint'(x_out), 777);

        // R5: synchronous reset clears a loaded value
        @(negedge clk);
        drive_value(MR - 2);
        rst = 1'b1;
        @(negedge clk);
        check("R5 reset clears", longint'(x_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R5 resume after reset", longint'(x_out), MR - 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule